// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Engine

This block moves 32-bit audio samples between system memory and a single device data port. Software builds a circular list of descriptors in memory. Each descriptor gives a memory buffer address, a device address, a word count and a direction. Software then writes a start command, with the address of the first descriptor, into a 64-bit order register. The engine fetches that descriptor and moves its words one at a time. When the count runs out it raises a one-cycle interrupt and follows the next pointer to the next descriptor. A ring of descriptors therefore plays or captures without end until software stops it.

Software finds the play position with a snapshot command. The engine writes its live copy of the current descriptor back to a memory address that software names. The buffer address in that copy has already been advanced past every word moved. Snapshot, start and stop are handshakes: each bit reads back as 1 while its command is pending and clears when the command has been carried out. All memory and device traffic goes over one word-wide request port. Each request is held until it is acknowledged.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset the order register reads 0, no memory request is raised and the interrupt is low.
- R2: A write to the order register stores bits 63:5 (the descriptor address) and bits 1:0 (uncached and 64-bit flags), and both read back as written. Bits 4, 3 and 2 read back only as the stop, start and snapshot pending flags.
- R3: A write with bit 3 set in the idle engine makes the engine read descriptor words 0 to 9 from the byte address in bits 63:5 (32-byte aligned), one word every 4 bytes. Bit 3 reads 1 from the cycle after the write until the last of those reads is acknowledged.
- R4: Descriptor word 1 is the memory address, word 2 the device address, word 3 the length in words and word 6 the command. If command bit 12 is 1, each word is read from the memory address and then written to the device address. If bit 12 is 0, each word is read from the device address and written to the memory address. After every word the memory address grows by 4 and the length shrinks by 1.
- R5: Every request has a word-aligned address, and its address and direction stay unchanged until it is acknowledged.
- R6: When an enabled descriptor's length reaches zero, the interrupt is high for exactly one cycle. No memory request is raised in that cycle, and the next descriptor fetch comes later.
- R7: If bit 0 of descriptor word 0 is 1, the engine next fetches the descriptor at word 0 with its low 5 bits cleared, so a last descriptor that points at the first one forms an endless ring. If bit 0 is 0, the engine goes idle.
- R8: A write with bit 2 set makes the engine write 16 words to the 32-byte aligned address in bits 63:5. Words 0 to 9 hold the live descriptor state, with the advanced address and the remaining length, and words 10 to 15 are zero. This happens while running or idle, and bit 2 clears when the last write is acknowledged.
- R9: A write with bit 4 set while the engine is busy takes effect only between words: every word read is followed by its write. Bit 4 reads 1 until the engine halts. The engine then raises no request until a new start.
- R10: A start written while the engine is busy is ignored: bit 3 stays 0 and the transfer continues unchanged.
- R11: A descriptor with command bit 0 clear moves no words and raises no interrupt. The engine then follows its next pointer as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ord_we | input | 1 | Order register write strobe |
| ord_wdata | input | 64 | Order register write value |
| ord_rdata | output | 64 | Order register read value |
| mem_req | output | 1 | Word request valid |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Descriptor completion pulse |

## Verification
A fault in the word counter or the address step shows at the ports within one word. A playback stream written to the device breaks from the arithmetic buffer pattern at that word. A later snapshot of the live state then disagrees with the number of words the device has received. A fault in ring traversal shows as a wrong sample at the first descriptor boundary or at the wrap. A fault in the pending-flag handshake shows in the order register read-back one cycle after the command. A premature or doubled completion shows as an interrupt count that no longer equals the number of words moved divided by the descriptor length.

// File: rtl/ring_dma_engine.sv
module ring_dma_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ord_we,
  input  logic [63:0]   ord_wdata,
  output logic [63:0]   ord_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int NW = 16;
  localparam int LW = 10;
  localparam int IW = $clog2(NW);
  localparam int B_STOP = 4;
  localparam int B_START = 3;
  localparam int B_ASK = 2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_BOUND, S_RD, S_WR, S_WB, S_NEXT} st_t;

  st_t            st;
  logic [IW-1:0]  widx;
  logic [31:0]    d [NW];
  logic [31:0]    buf_q;
  logic [AW-1:0]  fetch_base, ask_base;
  logic [58:0]    addr_q;
  logic [1:0]     ctl_q;
  logic           start_p, ask_p, stop_p, wb_run;

  wire            play     = d[6][12];
  wire            en       = d[6][0];
  wire [AW-1:0]   saddr    = d[1][AW-1:0];
  wire [AW-1:0]   daddr    = d[2][AW-1:0];
  wire [AW-1:0]   off      = AW'({widx, 2'b00});
  wire [AW-1:0]   nxt_base = {d[0][AW-1:5], 5'b0};
  wire            last_fetch = widx == IW'(LW - 1);
  wire            last_wb    = widx == IW'(NW - 1);

  assign ord_rdata = {addr_q, stop_p, start_p, ask_p, ctl_q};
  assign mem_req   = st inside {S_FETCH, S_RD, S_WR, S_WB};
  assign mem_we    = st inside {S_WR, S_WB};
  assign mem_wdata = (st == S_WB) ? d[widx] : buf_q;
  assign irq       = (st == S_NEXT) && en;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = fetch_base + off;
      S_RD:    mem_addr = play ? saddr : daddr;
      S_WR:    mem_addr = play ? daddr : saddr;
      S_WB:    mem_addr = ask_base + off;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      widx <= '0;
      for (int i = 0; i < NW; i++) d[i] <= '0;
      buf_q <= '0;
      fetch_base <= '0;
      ask_base <= '0;
      addr_q <= '0;
      ctl_q <= '0;
      start_p <= 1'b0;
      ask_p <= 1'b0;
      stop_p <= 1'b0;
      wb_run <= 1'b0;
    end else begin
      if (ord_we) begin
        addr_q <= ord_wdata[63:5];
        ctl_q  <= ord_wdata[1:0];
        if (ord_wdata[B_START] && st == S_IDLE && !start_p) begin
          start_p    <= 1'b1;
          fetch_base <= {ord_wdata[AW-1:5], 5'b0};
        end
        if (ord_wdata[B_ASK] && !ask_p) begin
          ask_p    <= 1'b1;
          ask_base <= {ord_wdata[AW-1:5], 5'b0};
        end
        if (ord_wdata[B_STOP] && st != S_IDLE) stop_p <= 1'b1;
      end

      case (st)
        S_IDLE: begin
          widx <= '0;
          if (ask_p) begin
            wb_run <= 1'b0;
            st <= S_WB;
          end else if (start_p) st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          d[widx] <= mem_rdata;
          widx <= widx + 1'b1;
          if (last_fetch) begin
            start_p <= 1'b0;
            st <= S_BOUND;
          end
        end
        S_BOUND: begin
          widx <= '0;
          if (ask_p) begin
            wb_run <= 1'b1;
            st <= S_WB;
          end else if (d[3] == '0 || !en) st <= S_NEXT;
          else if (stop_p) begin
            stop_p <= 1'b0;
            st <= S_IDLE;
          end else st <= S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st <= S_WR;
        end
        S_WR: if (mem_ack) begin
          d[1] <= d[1] + 32'd4;
          d[3] <= d[3] - 32'd1;
          st <= S_BOUND;
        end
        S_WB: if (mem_ack) begin
          widx <= widx + 1'b1;
          if (last_wb) begin
            ask_p <= 1'b0;
            if (wb_run) st <= S_BOUND;
            else begin
              stop_p <= 1'b0;
              st <= S_IDLE;
            end
          end
        end
        S_NEXT: begin
          widx <= '0;
          if (stop_p || !d[0][0]) begin
            stop_p <= 1'b0;
            st <= S_IDLE;
          end else begin
            fetch_base <= nxt_base;
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [63:0]   ord_rdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          irq
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R5
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mem_req);
  // R8
  ask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ord_rdata[2]) |-> $past(mem_req && mem_we && mem_ack));
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ord_rdata[3]) |-> $past(mem_req && !mem_we && mem_ack));
endmodule

bind ring_dma_engine ring_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ord_rdata(ord_rdata), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
);

// File: tb/tb_ring_dma_engine.sv
`timescale 1ns/1ps
module tb_ring_dma_engine;
  localparam logic [31:0] DEV = 32'h0F00;
  localparam logic [31:0] PBUF = 32'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ord_we = 1'b0;
  logic [63:0] ord_wdata = '0;
  logic [63:0] ord_rdata;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [1024];
  logic [31:0] dev_log [256];
  logic [31:0] dev_val, hold_addr;
  int cnt, lat, dev_n, buf_rd, irq_n, irq_bad, bad5, cyc;
  bit hold_v;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ring_dma_engine #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_wdata(ord_wdata),
    .ord_rdata(ord_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_ack   = mem_req && (cnt >= lat);
  assign mem_rdata = (mem_addr == DEV) ? dev_val : mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; dev_val <= 32'h5000; dev_n <= 0; buf_rd <= 0;
      irq_n <= 0; irq_bad <= 0; bad5 <= 0; hold_v <= 1'b0; hold_addr <= '0;
    end else begin
      if (irq) begin
        irq_n <= irq_n + 1;
        if (mem_req) irq_bad <= irq_bad + 1;
      end
      if (hold_v && (!mem_req || mem_addr != hold_addr)) bad5 <= bad5 + 1;
      if (mem_req && mem_addr[1:0] != 2'b00) bad5 <= bad5 + 1;
      hold_v <= mem_req && !mem_ack;
      hold_addr <= mem_addr;
      if (mem_req && !mem_ack) cnt <= cnt + 1; else cnt <= 0;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (mem_addr == DEV) begin
            dev_log[dev_n[7:0]] <= mem_wdata;
            dev_n <= dev_n + 1;
          end else mem[mem_addr[11:2]] = mem_wdata;
        end else if (mem_addr == DEV) dev_val <= dev_val + 1;
        else if (mem_addr >= PBUF && mem_addr < 32'h0500) buf_rd <= buf_rd + 1;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ord_write(input logic [63:0] v);
    @(negedge clk);
    ord_we = 1'b1; ord_wdata = v;
    @(negedge clk);
    ord_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] sa,
                          input logic [31:0] len, input logic [31:0] cmd);
    int b;
    b = a[11:2];
    mem[b] = nxt; mem[b+1] = sa; mem[b+2] = DEV; mem[b+3] = len;
    mem[b+4] = 0; mem[b+5] = 1; mem[b+6] = cmd;
    mem[b+7] = 0; mem[b+8] = 0; mem[b+9] = 0;
    for (int i = 10; i < 16; i++) mem[b+i] = 32'hDEAD0000 + i;
  endtask

  task automatic wait_bit_low(input int bitn);
    for (int i = 0; i < 4000; i++) begin
      if (!ord_rdata[bitn]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_irq(input int n);
    for (int i = 0; i < 6000; i++) begin
      if (irq_n >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(input int lt, input int ln);
    int ring, k, busy, bad, wb;
    logic [31:0] w [16];
    lat = lt;
    ring = 3 * ln;

    do_reset();
    // R1
    check(ord_rdata == 64'd0, "R1 order reset", ord_rdata, 0);
    check(!mem_req && !irq, "R1 quiet reset", {mem_req, irq}, 0);

    // R2
    ord_write(64'hABCD_0123_4567_89E3);
    check(ord_rdata == 64'hABCD_0123_4567_89E3 & ~64'h1C, "R2 readback", ord_rdata,
          64'hABCD_0123_4567_89E3 & ~64'h1C);

    // playback ring of three descriptors
    for (int i = 0; i < 3; i++)
      put_desc(32'h100 + i * 32'h40, (32'h100 + ((i + 1) % 3) * 32'h40) | 1,
               PBUF + i * ln * 4, ln, 32'h1001);
    for (int i = 0; i < ring; i++) mem[PBUF[11:2] + i] = 32'hA000 + i;

    ord_write(64'h100 | 64'h8);
    check(ord_rdata[3] == 1'b1, "R3 start pending", ord_rdata[3], 1);
    wait_irq(1);
    check(ord_rdata[3] == 1'b0, "R3 start cleared", ord_rdata[3], 0);

    // R10
    ord_write(64'h200 | 64'h8);
    check(ord_rdata[3] == 1'b0, "R10 start ignored", ord_rdata[3], 0);

    // R8 snapshot while running
    ord_write(64'h800 | 64'h4);
    wait_bit_low(2);
    for (int i = 0; i < 16; i++) w[i] = mem[32'h200 + i];
    k = (w[1] - PBUF) / 4;
    check(w[2] == DEV && w[6] == 32'h1001 && w[4] == 0 && w[5] == 1, "R8 live fields",
          {w[2], w[6]}, {DEV, 32'h1001});
    bad = 0;
    for (int i = 10; i < 16; i++) if (w[i] != 0) bad++;
    check(bad == 0, "R8 reserved zero", bad, 0);
    check(((k + w[3]) % ln) == 0 && w[3] <= ln && (k + w[3]) > 0 && (k + w[3]) <= ring,
          "R8 position", {k, w[3]}, ln);
    wb = (k + w[3]) / ln;
    if (wb < 1) wb = 1;
    check(w[0] == ((32'h100 + (wb % 3) * 32'h40) | 1), "R7 next pointer", w[0],
          (32'h100 + (wb % 3) * 32'h40) | 1);

    wait_irq(4);
    check(irq_n >= 4, "R7 ring wrap", irq_n, 4);

    // R9
    ord_write(64'h10);
    check(ord_rdata[4] == 1'b1, "R9 stop pending", ord_rdata[4], 1);
    wait_bit_low(4);
    busy = 0;
    repeat (30) begin
      @(negedge clk);
      if (mem_req) busy++;
    end
    check(busy == 0, "R9 idle after stop", busy, 0);
    check(buf_rd == dev_n, "R9 whole words", buf_rd, dev_n);

    // R4 playback stream
    bad = 0;
    for (int n = 0; n < dev_n && n < 256; n++)
      if (dev_log[n] != 32'hA000 + (n % ring)) bad++;
    check(bad == 0 && dev_n > 0, "R4 playback stream", bad, 0);
    // R6
    check(irq_n == dev_n / ln, "R6 irq count", irq_n, dev_n / ln);
    check(irq_bad == 0, "R6 irq without request", irq_bad, 0);

    // R8 snapshot while idle
    ord_write(64'h880 | 64'h4);
    wait_bit_low(2);
    k = (mem[32'h220 + 1] - PBUF) / 4;
    check((k % ring) == (dev_n % ring), "R8 idle position", k % ring, dev_n % ring);
    check(((k + mem[32'h220 + 3]) % ln) == 0, "R8 idle length", mem[32'h220 + 3], ln);
    check(bad5 == 0, "R5 request hold", bad5, 0);

    // capture with a disabled descriptor first
    do_reset();
    put_desc(32'h200, 32'h240 | 1, 32'h700, ln, 32'h1000);
    put_desc(32'h240, 32'h0, 32'h600, ln, 32'h0001);
    ord_write(64'h200 | 64'h8);
    busy = 0;
    for (int i = 0; i < 4000 && busy < 20; i++) begin
      @(negedge clk);
      if (mem_req || ord_rdata[4:2] != 0) busy = 0; else busy++;
    end
    check(busy >= 20, "R7 idle on invalid next", busy, 20);
    bad = 0;
    for (int j = 0; j < ln; j++) if (mem[32'h180 + j] != 32'h5000 + j) bad++;
    check(bad == 0, "R4 capture data", bad, 0);
    bad = 0;
    for (int j = 0; j < ln; j++) if (mem[32'h1C0 + j] != 0) bad++;
    check(bad == 0, "R11 disabled moves nothing", bad, 0);
    check(irq_n == 1, "R11 single irq", irq_n, 1);
    check(dev_n == 0, "R4 no device writes in capture", dev_n, 0);
    check(bad5 == 0, "R5 request hold capture", bad5, 0);
  endtask

  initial begin
    cyc = 0;
    for (int lt = 0; lt < 3; lt++)
      for (int ln = 1; ln <= 3; ln++)
        run_cfg(lt, ln);
    finish_run();
  end
endmodule